// File: doc/BRIEF.md
# Big-Endian Control Register Bank

This block is a small memory-mapped bank that holds two 32-bit system control words, a 32-bit interrupt status word, a 32-bit interrupt mask word and a SCSI status byte. A host reaches it through a single request channel. Each request carries an address, a write flag, write data and a byte count of 1, 2 or 4. Sub-word accesses to the control words pick lanes in big-endian order: byte offset 0 is the most significant byte. A read takes the selected field and returns it right-aligned. A write replaces only that field.

Writes to the second control word have two side effects. A fault counter advances whenever the written word has bit 0 set, and it emits a flash pulse each time it wraps. The bank also presents the middle byte (bits 15:8) of the new word, together with the middle byte it held before the write, to an external serial clock block on a one-cycle strobe. Writes to the SCSI command byte can pulse a reset output, clear bits in the stored SCSI status and set or clear one interrupt status bit.

Requests are accepted on every cycle in which `req_valid` is high; there is no back-pressure. Every read request produces exactly one response beat, with `rsp_valid` high in the next cycle. The response channel cannot stall, so the consumer must accept each beat as it comes. Write requests produce no response beat.

Top module: `cfg_bank_be`

## Requirements
- R1: After reset, control word A reads 0x00011102, control word B reads 0x00FF0C80, interrupt status and mask read 0, and the SCSI status byte reads SCSI_ST_INIT (default 0xE1).
- R2: Control word A decodes at 0xC000..0xC003 and B at 0xD000..0xD003. For byte offset o = addr[1:0] and size s, a read returns bits [(4-o-s)*8 +: s*8] zero-extended into rsp_data.
- R3: A write to a control word takes the low s*8 bits of req_wdata, places them at bit (4-o-s)*8 and keeps every other bit of that word.
- R4: An access is unmapped if its size is not 1, 2 or 4, or if o+s exceeds 4.
- R5: A write to word B pulses rtc_stb in the next cycle. In that cycle rtc_new is bits 15:8 of the new word and rtc_old is bits 15:8 of word B before the write (0x0C right after reset).
- R6: Each write that leaves bit 0 of word B set advances the fault counter. The tenth such write wraps the counter to 0 and pulses led_flash in the next cycle.
- R7: Interrupt status (0x7000) and mask (0x7800) are full 32-bit read/write registers. They respond only to size-4 accesses at exactly those addresses.
- R8: A size-1 write to 0x14020 with bit 1 (0x02) set clears bits 7, 5 and 0 of the SCSI status byte and pulses scsi_rst in the next cycle.
- R9: A size-1 write to 0x14020 sets interrupt status bit 26 when data bit 4 (0x10) is 1 and clears it when that bit is 0. All other status bits keep their values.
- R10: A size-1 read of 0x14020 returns the SCSI status byte, and a size-1 read of 0x14021 returns 0x40. Writes to 0x14021 have no effect.
- R11: An unmapped read returns 0, and an unmapped write changes no register and pulses no output.
- R12: Each read request produces a response beat one cycle later, and no beat appears for a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (20) | Byte address |
| req_size | input | 3 | Byte count: 1, 2 or 4 |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read response beat |
| rsp_data | output | 32 | Read data, right-aligned |
| rtc_stb | output | 1 | One-cycle strobe after a write to word B |
| rtc_new | output | 8 | Middle byte of word B after the write |
| rtc_old | output | 8 | Middle byte of word B before the write |
| led_flash | output | 1 | Fault counter wrap pulse |
| scsi_rst | output | 1 | SCSI reset pulse |

## Verification
The in-module assertions are checked on every cycle. They check that the saved copy of word B follows every write to it, that a flash pulse only comes with a counter at zero, and that a SCSI reset pulse leaves the cleared status bits at zero. They also check that the SCSI command tracks interrupt bit 26, that unmapped writes disturb no register, and that responses appear one cycle after each read. The actual lane placement, the reset values, the exact byte presented to the clock block and the tenth-write wrap can only be shown by the bench. It compares every response against a reference model over directed corner cases and seeded random traffic.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CTLA,
    TGT_CTLB,
    TGT_ISTAT,
    TGT_IMASK,
    TGT_SCSI_CMD,
    TGT_SCSI_AUX
  } tgt_e;

  // Right-aligned mask for a byte count of 1, 2 or 4.
  function automatic logic [31:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    size_mask = 32'h0000_00FF;
      3'd2:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_bank_pkg::*;
#(
  parameter int AW         = 20,
  parameter int CTLA_BASE  = 'hC000,
  parameter int CTLB_BASE  = 'hD000,
  parameter int ISTAT_ADDR = 'h7000,
  parameter int IMASK_ADDR = 'h7800,
  parameter int SCSI_ADDR  = 'h14020
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size,
  output tgt_e          tgt,
  output logic [1:0]    off
);
  localparam logic [AW-1:0] A_BASE = AW'(CTLA_BASE);
  localparam logic [AW-1:0] B_BASE = AW'(CTLB_BASE);
  localparam logic [AW-1:0] IS_A   = AW'(ISTAT_ADDR);
  localparam logic [AW-1:0] IM_A   = AW'(IMASK_ADDR);
  localparam logic [AW-1:0] SC_A   = AW'(SCSI_ADDR);
  localparam logic [AW-1:0] AUX_A  = AW'(SCSI_ADDR + 1);

  logic       size_ok;
  logic [3:0] span;
  logic       ctl_ok;

  always_comb begin
    size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    span    = {2'b00, addr[1:0]} + {1'b0, size};
    ctl_ok  = size_ok && (span <= 4'd4);
    off     = addr[1:0];
    tgt     = TGT_NONE;
    if (ctl_ok && addr[AW-1:2] == A_BASE[AW-1:2])      tgt = TGT_CTLA;
    else if (ctl_ok && addr[AW-1:2] == B_BASE[AW-1:2]) tgt = TGT_CTLB;
    else if (size == 3'd4 && addr == IS_A)             tgt = TGT_ISTAT;
    else if (size == 3'd4 && addr == IM_A)             tgt = TGT_IMASK;
    else if (size == 3'd1 && addr == SC_A)             tgt = TGT_SCSI_CMD;
    else if (size == 3'd1 && addr == AUX_A)            tgt = TGT_SCSI_AUX;
  end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_bank_pkg::*;
(
  input  logic [31:0] reg_val,
  input  logic [1:0]  off,
  input  logic [2:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rd_field,
  output logic [31:0] wr_merged
);
  logic [2:0]  lanes_below;
  logic [4:0]  sh;
  logic [31:0] msk;

  always_comb begin
    lanes_below = 3'd4 - {1'b0, off} - size;
    sh          = {lanes_below[1:0], 3'b000};
    msk         = size_mask(size);
    rd_field    = (reg_val >> sh) & msk;
    wr_merged   = (reg_val & ~(msk << sh)) | ((wdata & msk) << sh);
  end
endmodule

// File: rtl/cfg_fault_ctr.sv
module cfg_fault_ctr #(
  parameter int WRAP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  output logic flash
);
  localparam int CW = (WRAP > 2) ? $clog2(WRAP) : 1;
  localparam logic [CW-1:0] LAST = CW'(WRAP - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flash <= 1'b0;
    end else begin
      flash <= bump && (cnt_q == LAST);
      if (bump) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R6
  flash_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash |-> cnt_q == '0);
endmodule

// File: rtl/cfg_bank_be.sv
module cfg_bank_be
  import cfg_bank_pkg::*;
#(
  parameter int          AW           = 20,
  parameter logic [31:0] CTLA_INIT    = 32'h0001_1102,
  parameter logic [31:0] CTLB_INIT    = 32'h00FF_0C80,
  parameter logic [7:0]  SCSI_ST_INIT = 8'hE1,
  parameter int          LED_WRAP     = 10,
  parameter int          IRQ_SCSI_BIT = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          rtc_stb,
  output logic [7:0]    rtc_new,
  output logic [7:0]    rtc_old,
  output logic          led_flash,
  output logic          scsi_rst
);
  localparam int NCTL = 2;
  localparam logic [7:0] SCSI_CLR = 8'hA1;

  tgt_e        tgt;
  logic [1:0]  off;
  logic [31:0] ctl_q    [NCTL];
  logic [31:0] rd_field [NCTL];
  logic [31:0] merged   [NCTL];
  logic [NCTL-1:0] ctl_wr;
  logic [31:0] prev_b_q;
  logic [31:0] istat_q, imask_q;
  logic [7:0]  scsi_st_q;
  logic        wr_go, rd_go, scsi_wr;
  logic [31:0] rd_mux;

  assign wr_go   = req_valid && req_write;
  assign rd_go   = req_valid && !req_write;
  assign scsi_wr = wr_go && (tgt == TGT_SCSI_CMD);

  cfg_addr_dec #(.AW(AW)) u_dec (
    .addr(req_addr), .size(req_size), .tgt(tgt), .off(off)
  );

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    localparam logic [31:0] INIT = (i == 0) ? CTLA_INIT : CTLB_INIT;
    localparam tgt_e        SEL  = (i == 0) ? TGT_CTLA : TGT_CTLB;

    cfg_lane_unit u_lane (
      .reg_val(ctl_q[i]), .off(off), .size(req_size), .wdata(req_wdata),
      .rd_field(rd_field[i]), .wr_merged(merged[i])
    );

    assign ctl_wr[i] = wr_go && (tgt == SEL);

    always_ff @(posedge clk) begin
      if (!rst_n)         ctl_q[i] <= INIT;
      else if (ctl_wr[i]) ctl_q[i] <= merged[i];
    end
  end

  cfg_fault_ctr #(.WRAP(LED_WRAP)) u_led (
    .clk(clk), .rst_n(rst_n), .bump(ctl_wr[1] && merged[1][0]), .flash(led_flash)
  );

  always_comb begin
    case (tgt)
      TGT_CTLA:     rd_mux = rd_field[0];
      TGT_CTLB:     rd_mux = rd_field[1];
      TGT_ISTAT:    rd_mux = istat_q;
      TGT_IMASK:    rd_mux = imask_q;
      TGT_SCSI_CMD: rd_mux = {24'h0, scsi_st_q};
      TGT_SCSI_AUX: rd_mux = 32'h0000_0040;
      default:      rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rtc_stb   <= 1'b0;
      rtc_new   <= CTLB_INIT[15:8];
      rtc_old   <= CTLB_INIT[15:8];
      prev_b_q  <= CTLB_INIT;
      istat_q   <= '0;
      imask_q   <= '0;
      scsi_st_q <= SCSI_ST_INIT;
      scsi_rst  <= 1'b0;
    end else begin
      rsp_valid <= rd_go;
      rsp_data  <= rd_go ? rd_mux : 32'h0;
      rtc_stb   <= ctl_wr[1];
      scsi_rst  <= scsi_wr && req_wdata[1];
      if (ctl_wr[1]) begin
        rtc_new  <= merged[1][15:8];
        rtc_old  <= prev_b_q[15:8];
        prev_b_q <= merged[1];
      end
      if (wr_go && tgt == TGT_IMASK) imask_q <= req_wdata;
      if (wr_go && tgt == TGT_ISTAT) istat_q <= req_wdata;
      else if (scsi_wr)              istat_q[IRQ_SCSI_BIT] <= req_wdata[4];
      if (scsi_wr && req_wdata[1])   scsi_st_q <= scsi_st_q & ~SCSI_CLR;
    end
  end

  // R5
  prev_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr[1] |=> prev_b_q == ctl_q[1]);

  // R8
  scsi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scsi_rst |-> (scsi_st_q & SCSI_CLR) == 8'h00);

  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scsi_wr |=> istat_q[IRQ_SCSI_BIT] == $past(req_wdata[4]));

  // R11
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && tgt == TGT_NONE) |=> $stable(ctl_q[0]) && $stable(ctl_q[1])
      && $stable(istat_q) && $stable(imask_q) && $stable(scsi_st_q)
      && !rtc_stb && !scsi_rst && !led_flash);

  // R12
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);

  // R12
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_go) |=> !rsp_valid);
endmodule

// File: tb/sim_cfg_bank_be.sv
module sim_cfg_bank_be;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rtc_stb, led_flash, scsi_rst;
  logic [31:0] rsp_data;
  logic [7:0]  rtc_new, rtc_old;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_a, m_b, m_ist, m_imk;
  logic [7:0]  m_sst;
  int          m_led;

  always #5 clk = ~clk;

  cfg_bank_be u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rtc_stb(rtc_stb),
    .rtc_new(rtc_new), .rtc_old(rtc_old), .led_flash(led_flash), .scsi_rst(scsi_rst)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // 0 none, 1 A, 2 B, 3 istat, 4 imask, 5 scsi cmd, 6 scsi aux
  function automatic int decode(input logic [19:0] a, input logic [2:0] s);
    bit ok = (s == 1 || s == 2 || s == 4) && (int'(a[1:0]) + int'(s) <= 4);
    if (ok && a[19:2] == 18'(20'hC000 >> 2)) return 1;
    if (ok && a[19:2] == 18'(20'hD000 >> 2)) return 2;
    if (s == 4 && a == 20'h07000) return 3;
    if (s == 4 && a == 20'h07800) return 4;
    if (s == 1 && a == 20'h14020) return 5;
    if (s == 1 && a == 20'h14021) return 6;
    return 0;
  endfunction

  function automatic logic [31:0] fmask(input logic [2:0] s);
    return (s == 1) ? 32'hFF : (s == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] get_f(input logic [31:0] r, input logic [1:0] o,
                                        input logic [2:0] s);
    int sh = (4 - int'(o) - int'(s)) * 8;
    return (r >> sh) & fmask(s);
  endfunction

  function automatic logic [31:0] put_f(input logic [31:0] r, input logic [1:0] o,
                                        input logic [2:0] s, input logic [31:0] d);
    int sh = (4 - int'(o) - int'(s)) * 8;
    return (r & ~(fmask(s) << sh)) | ((d & fmask(s)) << sh);
  endfunction

  task automatic op(input bit we, input logic [19:0] a, input logic [2:0] s,
                    input logic [31:0] d);
    int t = decode(a, s);
    logic [31:0] exp_rd = 0, nb;
    bit e_stb = 0, e_fl = 0, e_rst = 0;
    logic [7:0] e_new = 0, e_old = 0;
    string tag;
    case (t)
      1: exp_rd = get_f(m_a, a[1:0], s);
      2: exp_rd = get_f(m_b, a[1:0], s);
      3: exp_rd = m_ist;
      4: exp_rd = m_imk;
      5: exp_rd = {24'h0, m_sst};
      6: exp_rd = 32'h40;
      default: exp_rd = 0;
    endcase
    tag = (t == 0) ? "R11/R4" : (t <= 2) ? "R2" : (t <= 4) ? "R7" : "R10";
    if (we) begin
      case (t)
        1: m_a = put_f(m_a, a[1:0], s, d);
        2: begin
          nb = put_f(m_b, a[1:0], s, d);
          e_stb = 1; e_new = nb[15:8]; e_old = m_b[15:8];
          if (nb[0]) begin
            m_led++;
            if (m_led == 10) begin m_led = 0; e_fl = 1; end
          end
          m_b = nb;
        end
        3: m_ist = d;
        4: m_imk = d;
        5: begin
          m_ist[26] = d[4];
          if (d[1]) begin m_sst = m_sst & 8'h5E; e_rst = 1; end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_size = s; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0;
    chk(rsp_valid == !we, "R12 rsp_valid", 32'(rsp_valid), 32'(!we));
    if (!we) chk(rsp_data == exp_rd, tag, rsp_data, exp_rd);
    chk(rtc_stb == e_stb, "R5 rtc_stb", 32'(rtc_stb), 32'(e_stb));
    if (e_stb) begin
      chk(rtc_new == e_new, "R5 rtc_new", 32'(rtc_new), 32'(e_new));
      chk(rtc_old == e_old, "R5 rtc_old", 32'(rtc_old), 32'(e_old));
    end
    chk(led_flash == e_fl, "R6 led_flash", 32'(led_flash), 32'(e_fl));
    chk(scsi_rst == e_rst, "R8 scsi_rst", 32'(scsi_rst), 32'(e_rst));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] pool [10];
    void'($urandom(32'd1234));
    pool = '{20'h0C000, 20'h0D000, 20'h07000, 20'h07800, 20'h14020,
             20'h14021, 20'h07001, 20'h06000, 20'h14108, 20'h00000};
    m_a = 32'h0001_1102; m_b = 32'h00FF_0C80; m_ist = 0; m_imk = 0;
    m_sst = 8'hE1; m_led = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset values
    op(0, 20'h0C000, 4, 0);
    op(0, 20'h0D000, 4, 0);
    op(0, 20'h07000, 4, 0);
    op(0, 20'h07800, 4, 0);
    op(0, 20'h14020, 1, 0);
    // R2 big-endian lanes
    op(0, 20'h0D001, 1, 0);
    op(0, 20'h0C002, 2, 0);
    op(0, 20'h0C003, 1, 0);
    // R3 byte write keeps neighbours
    op(1, 20'h0D002, 1, 32'hFFFF_FF5A);
    op(0, 20'h0D000, 4, 0);
    op(1, 20'h0C001, 2, 32'h0000_BEEF);
    op(0, 20'h0C000, 4, 0);
    // R4 out-of-range size 2 and illegal size 3
    op(1, 20'h0C003, 2, 32'h1234);
    op(0, 20'h0C003, 2, 0);
    op(1, 20'h0D000, 3, 32'h00AB_CDEF);
    op(0, 20'h0C000, 4, 0);
    op(0, 20'h0D000, 4, 0);
    // R7 status/mask, and sub-word access refused
    op(1, 20'h07800, 4, 32'hCAFE_F00D);
    op(0, 20'h07800, 4, 0);
    op(1, 20'h07000, 4, 32'h0000_0011);
    op(0, 20'h07000, 2, 0);
    // R9 SCSI interrupt bit set then cleared
    op(1, 20'h14020, 1, 32'h10);
    op(0, 20'h07000, 4, 0);
    op(1, 20'h14020, 1, 32'h00);
    op(0, 20'h07000, 4, 0);
    // R8 SCSI reset, R10 aux read and ignored write
    op(1, 20'h14020, 1, 32'h02);
    op(0, 20'h14020, 1, 0);
    op(1, 20'h14021, 1, 32'hFF);
    op(0, 20'h14021, 1, 0);
    op(0, 20'h14020, 1, 0);
    // R11 unmapped
    op(1, 20'h06000, 4, 32'hFFFF_FFFF);
    op(0, 20'h06000, 4, 0);
    // R6 ten faults wrap
    for (int i = 0; i < 12; i++) op(1, 20'h0D003, 1, 32'h01);
    op(1, 20'h0D003, 1, 32'h00);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [19:0] a = pool[$urandom_range(0, 9)];
      logic [2:0]  s = 3'($urandom_range(1, 4));
      if (a == 20'h0C000 || a == 20'h0D000) a[1:0] = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) s = 3'd4;
      op(1'($urandom_range(0, 1)), a, s, $urandom());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule